// File: doc/BRIEF.md
# Base-and-Limit Address Relocation Guard

This block sits between a requesting master and memory and handles every access it makes. A user-mode request carries a logical address. The block compares that address with a limit register and adds a base register to it to form a physical address. If the logical address is out of range, the block returns a protection fault instead of an address. A kernel-mode request passes straight through untouched, so privileged code can reach every physical location.

Software loads the base and limit values through a small configuration write port. Each write carries its own privilege bit. Only a privileged write changes a register. An unprivileged attempt leaves both registers as they were and pulses a violation flag.

The result of a request is registered. It appears on the response outputs one clock after the request strobe. After reset both registers hold zero, so every user access faults until software programs a window.

Top module: `reloc_guard`

## Requirements
- R1: After reset the base and limit registers are zero: the response outputs and the violation flag are low, and any user request faults.
- R2: A user request whose logical address is strictly below the limit returns no fault. Its physical address is (logical address + base) modulo 2^AW, so a sum past the top of the space wraps around.
- R3: A user request whose logical address is equal to or above the limit returns rsp_fault=1 with rsp_paddr forced to zero.
- R4: A kernel request (req_kern=1) never faults and returns its logical address unchanged as the physical address, whatever the registers hold.
- R5: rsp_valid is high in exactly the cycle after a cycle with req_valid=1 and low otherwise. While rsp_valid is low, rsp_fault and rsp_paddr are zero.
- R6: A privileged write (cfg_we=1, cfg_kern=1) loads the base from cfg_wdata[AW-1:0] when cfg_sel=0, and the limit from cfg_wdata[AW:0] when cfg_sel=1. The new value applies to requests presented from the next cycle on; a request presented in the same cycle as the write uses the old value.
- R7: An unprivileged write (cfg_we=1, cfg_kern=0) changes neither register. It drives priv_viol high for exactly the one cycle after the attempt; a privileged write leaves priv_viol low.
- R8: The limit field is AW+1 bits wide. A limit of 2^AW (bit AW set) admits every logical address, including the all-ones address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request strobe |
| req_kern | input | 1 | Privilege of the request (1 = kernel) |
| req_laddr | input | AW | Logical address of the request |
| cfg_we | input | 1 | Register write strobe |
| cfg_kern | input | 1 | Privilege of the register write (1 = kernel) |
| cfg_sel | input | 1 | Register select: 0 = base, 1 = limit |
| cfg_wdata | input | AW+1 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after req_valid |
| rsp_fault | output | 1 | Protection fault for the request |
| rsp_paddr | output | AW | Physical address (zero on a fault) |
| priv_viol | output | 1 | One-cycle pulse after an unprivileged write attempt |

## Verification
A corrupted base register shows up as a shifted physical address on the first in-range user response. A corrupted limit shows up as a fault at a boundary address that should pass, or as a pass where a fault is due. In both cases the error is visible one clock after the request strobe. A privilege gate that leaks lets a user write through. That is caught at the next user response, which then reflects the illegal value, and by the missing priv_viol pulse one cycle after the attempt. A bad response register shows as rsp_valid high with no request, or as a fault that carries a non-zero address.

// File: rtl/reloc_guard_pkg.sv
package reloc_guard_pkg;

    // Register selected by a configuration write
    typedef enum logic {
        SEL_BASE  = 1'b0,
        SEL_LIMIT = 1'b1
    } reg_sel_e;

    // Outcome of one translation
    typedef enum logic [1:0] {
        XK_NONE  = 2'd0,
        XK_PASS  = 2'd1,
        XK_RELOC = 2'd2,
        XK_FAULT = 2'd3
    } xlate_kind_e;

    function automatic logic kind_valid(input xlate_kind_e k);
        return k != XK_NONE;
    endfunction

    function automatic logic kind_fault(input xlate_kind_e k);
        return k == XK_FAULT;
    endfunction

endpackage

// File: rtl/reloc_regs.sv
module reloc_regs
    import reloc_guard_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic          cfg_kern,
    input  logic          cfg_sel,
    input  logic [AW:0]   cfg_wdata,
    output logic [AW-1:0] base_q,
    output logic [AW:0]   limit_q,
    output logic          viol_q
);
    reg_sel_e sel;
    logic     wr_ok;

    assign sel   = reg_sel_e'(cfg_sel);
    assign wr_ok = cfg_we && cfg_kern;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            limit_q <= '0;
            viol_q  <= 1'b0;
        end else begin
            viol_q <= cfg_we && !cfg_kern;
            if (wr_ok) begin
                case (sel)
                    SEL_BASE:  base_q  <= cfg_wdata[AW-1:0];
                    SEL_LIMIT: limit_q <= cfg_wdata;
                    default:   ;
                endcase
            end
        end
    end
endmodule

// File: rtl/reloc_xlate.sv
module reloc_xlate
    import reloc_guard_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          req_valid,
    input  logic          req_kern,
    input  logic [AW-1:0] req_laddr,
    input  logic [AW-1:0] base,
    input  logic [AW:0]   limit,
    output xlate_kind_e   kind,
    output logic [AW-1:0] paddr
);
    logic [AW:0]   laddr_ext;
    logic          in_range;
    logic [AW-1:0] sum;

    assign laddr_ext = {1'b0, req_laddr};
    assign in_range  = laddr_ext < limit;
    assign sum       = req_laddr + base;

    always_comb begin
        kind  = XK_NONE;
        paddr = '0;
        if (req_valid) begin
            if (req_kern) begin
                kind  = XK_PASS;
                paddr = req_laddr;
            end else if (in_range) begin
                kind  = XK_RELOC;
                paddr = sum;
            end else begin
                kind  = XK_FAULT;
                paddr = '0;
            end
        end
    end
endmodule

// File: rtl/reloc_resp.sv
module reloc_resp
    import reloc_guard_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  xlate_kind_e   kind_d,
    input  logic [AW-1:0] paddr_d,
    output logic          rsp_valid,
    output logic          rsp_fault,
    output logic [AW-1:0] rsp_paddr
);
    xlate_kind_e   kind_q;
    logic [AW-1:0] paddr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q  <= XK_NONE;
            paddr_q <= '0;
        end else begin
            kind_q  <= kind_d;
            paddr_q <= paddr_d;
        end
    end

    assign rsp_valid = kind_valid(kind_q);
    assign rsp_fault = kind_fault(kind_q);
    assign rsp_paddr = paddr_q;
endmodule

// File: rtl/reloc_guard.sv
module reloc_guard
    import reloc_guard_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_kern,
    input  logic [AW-1:0] req_laddr,
    input  logic          cfg_we,
    input  logic          cfg_kern,
    input  logic          cfg_sel,
    input  logic [AW:0]   cfg_wdata,
    output logic          rsp_valid,
    output logic          rsp_fault,
    output logic [AW-1:0] rsp_paddr,
    output logic          priv_viol
);
    logic [AW-1:0] base_w;
    logic [AW:0]   limit_w;
    xlate_kind_e   kind_w;
    logic [AW-1:0] paddr_w;

    reloc_regs #(.AW(AW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_kern  (cfg_kern),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .base_q    (base_w),
        .limit_q   (limit_w),
        .viol_q    (priv_viol)
    );

    reloc_xlate #(.AW(AW)) u_xlate (
        .req_valid (req_valid),
        .req_kern  (req_kern),
        .req_laddr (req_laddr),
        .base      (base_w),
        .limit     (limit_w),
        .kind      (kind_w),
        .paddr     (paddr_w)
    );

    reloc_resp #(.AW(AW)) u_resp (
        .clk       (clk),
        .rst       (rst),
        .kind_d    (kind_w),
        .paddr_d   (paddr_w),
        .rsp_valid (rsp_valid),
        .rsp_fault (rsp_fault),
        .rsp_paddr (rsp_paddr)
    );
endmodule

// File: rtl/reloc_guard_chk.sv
module reloc_guard_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_kern,
    input logic [AW-1:0] req_laddr,
    input logic          cfg_we,
    input logic          cfg_kern,
    input logic [AW-1:0] base_w,
    input logic [AW:0]   limit_w,
    input logic          rsp_valid,
    input logic          rsp_fault,
    input logic [AW-1:0] rsp_paddr,
    input logic          priv_viol
);
    p_rsp_follows_req_r5: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    p_no_rsp_without_req_r5: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    p_fault_needs_valid_r3: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> rsp_valid);

    p_fault_zero_addr_r3: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (rsp_paddr == '0));

    p_kernel_passthru_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kern) |=> (!rsp_fault && rsp_paddr == $past(req_laddr)));

    p_user_in_range_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_kern && ({1'b0, req_laddr} < limit_w))
        |=> (!rsp_fault && rsp_paddr == $past(req_laddr + base_w)));

    p_user_out_range_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_kern && ({1'b0, req_laddr} >= limit_w)) |=> rsp_fault);

    p_viol_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !cfg_kern) |=> priv_viol);

    p_viol_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !(cfg_we && !cfg_kern) |=> !priv_viol);

    p_user_wr_keeps_regs_r7: assert property (@(posedge clk) disable iff (rst)
        !(cfg_we && cfg_kern) |=> ($stable(base_w) && $stable(limit_w)));
endmodule

bind reloc_guard reloc_guard_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_kern  (req_kern),
    .req_laddr (req_laddr),
    .cfg_we    (cfg_we),
    .cfg_kern  (cfg_kern),
    .base_w    (base_w),
    .limit_w   (limit_w),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_paddr (rsp_paddr),
    .priv_viol (priv_viol)
);

// File: tb/sim_reloc_guard.sv
`timescale 1ns/1ps
module sim_reloc_guard;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_kern = 1'b0;
    logic [AW-1:0] req_laddr = '0;
    logic          cfg_we = 1'b0;
    logic          cfg_kern = 1'b0;
    logic          cfg_sel = 1'b0;
    logic [AW:0]   cfg_wdata = '0;
    logic          rsp_valid;
    logic          rsp_fault;
    logic [AW-1:0] rsp_paddr;
    logic          priv_viol;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Bench model of the registers, updated from the requirements only
    logic [AW-1:0] m_base = '0;
    logic [AW:0]   m_limit = '0;

    always #10 clk = ~clk;

    reloc_guard #(.AW(AW)) u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_kern(req_kern), .req_laddr(req_laddr),
        .cfg_we(cfg_we), .cfg_kern(cfg_kern), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .priv_viol(priv_viol)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Issue one request at a negedge; returns at the next negedge with the response visible
    task automatic issue(input logic kern, input logic [AW-1:0] la);
        req_valid = 1'b1;
        req_kern  = kern;
        req_laddr = la;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_kern  = 1'b0;
    endtask

    task automatic expect_user(input string tag, input logic [AW-1:0] la);
        logic          ok;
        logic [AW-1:0] pa;
        ok = ({1'b0, la} < m_limit);
        pa = ok ? AW'(la + m_base) : '0;
        issue(1'b0, la);
        check({tag, " valid"}, 32'(rsp_valid), 32'd1);
        check({tag, " fault"}, 32'(rsp_fault), 32'(!ok));
        check({tag, " paddr"}, 32'(rsp_paddr), 32'(pa));
    endtask

    task automatic write_cfg(input logic kern, input logic sel, input logic [AW:0] d);
        cfg_we    = 1'b1;
        cfg_kern  = kern;
        cfg_sel   = sel;
        cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_we   = 1'b0;
        cfg_kern = 1'b0;
        if (kern) begin
            if (sel) m_limit = d;
            else     m_base  = d[AW-1:0];
        end
        check(kern ? "R6 no viol on kernel write" : "R7 viol pulse",
              32'(priv_viol), 32'(!kern));
    endtask

    task automatic t_reset;
        check("R1 rsp_valid at reset", 32'(rsp_valid), 32'd0);
        check("R1 priv_viol at reset", 32'(priv_viol), 32'd0);
        check("R1 rsp_fault at reset", 32'(rsp_fault), 32'd0);
        expect_user("R1 user addr 0 faults", 16'h0000);
        expect_user("R1 user addr 5 faults", 16'h0005);
    endtask

    task automatic t_program;
        write_cfg(1'b1, 1'b0, 17'h01000);
        write_cfg(1'b1, 1'b1, 17'h00100);
        check("R7 priv_viol stays low", 32'(priv_viol), 32'd0);
    endtask

    task automatic t_user_legal;
        expect_user("R2 low addr", 16'h0000);
        expect_user("R2 limit-1", 16'h00FF);
        expect_user("R2 mid", 16'h0042);
    endtask

    task automatic t_user_fault;
        expect_user("R3 at limit", 16'h0100);
        expect_user("R3 top addr", 16'hFFFF);
    endtask

    task automatic t_kernel;
        issue(1'b1, 16'hABCD);
        check("R4 kernel fault", 32'(rsp_fault), 32'd0);
        check("R4 kernel paddr", 32'(rsp_paddr), 32'h0000ABCD);
        issue(1'b1, 16'h0200);
        check("R4 kernel beyond limit", 32'(rsp_fault), 32'd0);
        check("R4 kernel paddr 2", 32'(rsp_paddr), 32'h00000200);
    endtask

    task automatic t_idle;
        issue(1'b0, 16'h0010);
        @(posedge clk);
        @(negedge clk);
        check("R5 no req no valid", 32'(rsp_valid), 32'd0);
        check("R5 idle paddr zero", 32'(rsp_paddr), 32'd0);
        check("R5 idle fault zero", 32'(rsp_fault), 32'd0);
    endtask

    task automatic t_user_write;
        write_cfg(1'b0, 1'b0, 17'h02222);
        @(posedge clk);
        @(negedge clk);
        check("R7 viol one cycle only", 32'(priv_viol), 32'd0);
        write_cfg(1'b0, 1'b1, 17'h10000);
        expect_user("R7 base and limit unchanged", 16'h0010);
        expect_user("R7 limit unchanged fault", 16'h0100);
    endtask

    task automatic t_same_cycle;
        // kernel write of base together with a user request: old base applies
        cfg_we = 1'b1; cfg_kern = 1'b1; cfg_sel = 1'b0; cfg_wdata = 17'h00500;
        req_valid = 1'b1; req_kern = 1'b0; req_laddr = 16'h0010;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0; cfg_kern = 1'b0; req_valid = 1'b0;
        check("R6 same-cycle uses old base", 32'(rsp_paddr), 32'(16'h1010));
        m_base = 16'h0500;
        expect_user("R6 next cycle new base", 16'h0010);
    endtask

    task automatic t_wrap;
        write_cfg(1'b1, 1'b0, 17'h0FFF0);
        write_cfg(1'b1, 1'b1, 17'h00020);
        issue(1'b0, 16'h0018);
        check("R2 wrap fault", 32'(rsp_fault), 32'd0);
        check("R2 wrap paddr", 32'(rsp_paddr), 32'h00000008);
    endtask

    task automatic t_full_limit;
        write_cfg(1'b1, 1'b0, 17'h00000);
        write_cfg(1'b1, 1'b1, 17'h10000);
        issue(1'b0, 16'hFFFF);
        check("R8 all-ones legal", 32'(rsp_fault), 32'd0);
        check("R8 all-ones paddr", 32'(rsp_paddr), 32'h0000FFFF);
        write_cfg(1'b1, 1'b1, 17'h0FFFF);
        expect_user("R8 below bit AW faults top", 16'hFFFF);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R5 watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_program();
        t_user_legal();
        t_user_fault();
        t_kernel();
        t_idle();
        t_user_write();
        t_same_cycle();
        t_wrap();
        t_full_limit();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule